// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the active-low select and strobe pins, the clock enable, the data mask, the bank select and address bit 10. It turns them into one decoded command and checks that command against the per-bank open/closed state and the device mode it keeps. Each command is registered and presented on a one-hot bus, together with the bank, the address-bit-10 flag, the device mode, an illegal-command pulse and a data enable. The open/closed state of each bank is also brought out.

Meaning depends on context. The clock-enable level of the previous cycle is registered inside the block and combined with the current level, and the device's burst status also counts. So the same pin pattern can be a refresh, a self-refresh entry or a clock-suspend entry, and in the low-power modes everything except the exit condition is ignored. The burst tracker uses a fixed burst of four and closes an auto-precharged bank when its burst ends.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With cs_n high the command is Deselect. With cs_n low, {ras_n,cas_n,we_n} decodes as 111 no-op, 110 burst stop, 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode set. cmd_o is one-hot, with bit 0 deselect, 1 no-op, 2 activate, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 mode set, 8 burst stop, 9 self-refresh entry, 10 self-refresh exit, 11 power-down entry, 12 power-down exit, 13 clock-suspend entry and 14 clock-suspend exit. It is valid right after the edge that sampled the pins and is all zero when a command is ignored.
- R2: Activate is legal only on a closed bank and opens it (bank_open_o bit n is bank n). Activate on an open bank raises illegal_o for that cycle and changes no state.
- R3: Read and write are legal only on an open bank, otherwise illegal_o is raised. ap_o shows a10 for read, write and precharge and is 0 for all other commands.
- R4: Precharge with a10 low closes only the addressed bank. With a10 high it closes all banks.
- R5: Mode set and auto refresh are legal only when every bank is closed.
- R6: A read or write sets a burst of four cycles. With a10 high, its bank closes at the fourth rising edge after the access while the clock stays enabled.
- R7: Burst stop ends the burst at once. A new read or write also ends it. An auto-precharged bank closes at that point unless the new access targets the same bank.
- R8: With clock enable high last cycle and low now, the auto-refresh encoding enters self refresh (mode_o = 1) when all banks are closed, and is illegal otherwise. Self refresh is left only when clock enable goes low to high with a no-op or deselect.
- R9: With clock enable falling and no burst running, a no-op or deselect enters power down (mode_o = 2). Any clock-enable rise leaves it.
- R10: A clock-enable fall while a burst is running enters clock suspend (mode_o = 3), with the burst count frozen. Clock enable high leaves it, and the burst resumes where it stopped.
- R11: In self refresh, power down and clock suspend, every command other than the exit is ignored: cmd_o is zero, illegal_o stays low and the bank state is unchanged.
- R12: data_en_o is high after an edge where clock enable was high in the previous cycle and dqm was low, and low otherwise.
- R13: After reset cmd_o is zero, mode_o is 0 (normal), all banks are closed, and illegal_o and ap_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge) |
| cmd_o | output | 15 | One-hot decoded command |
| bank_o | output | 2 | Bank of the registered command |
| ap_o | output | 1 | Precharge-all or auto-precharge flag |
| mode_o | output | 2 | Device mode: 0 normal, 1 self refresh, 2 power down, 3 clock suspend |
| illegal_o | output | 1 | Command illegal in the current state |
| data_en_o | output | 1 | Data in/out enabled for the cycle |
| bank_open_o | output | 4 | Open flag per bank |

## Verification
Every result except the auto-precharge close appears right after the rising edge that samples the pins. This covers the decoded command, flag, illegal pulse, mode, data enable and bank state. The auto-precharge close lands at the fourth edge after the access, and later if the clock is suspended in between. The bench changes inputs on the falling edge and reads outputs 1 ns after the rising edge. It counts NOPs explicitly to check that the bank is still open after the third and closed after the fourth. The clock-suspend test holds the clock low across several edges and then asks for power down. A clock-suspend entry on that request shows that the burst count did not move while suspended.

// File: rtl/sdr_trk_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes: command bit positions are fixed and shared by decoder, judge and checker.
package sdr_trk_pkg;

    typedef enum logic [1:0] {
        DM_NORMAL  = 2'd0,
        DM_SELFREF = 2'd1,
        DM_PWRDN   = 2'd2,
        DM_SUSPEND = 2'd3
    } dev_mode_e;

    localparam int NUM_CMD = 15;

    typedef logic [3:0] cmd_idx_t;

    localparam cmd_idx_t C_DESEL  = 4'd0;
    localparam cmd_idx_t C_NOP    = 4'd1;
    localparam cmd_idx_t C_ACT    = 4'd2;
    localparam cmd_idx_t C_RD     = 4'd3;
    localparam cmd_idx_t C_WR     = 4'd4;
    localparam cmd_idx_t C_PRE    = 4'd5;
    localparam cmd_idx_t C_AREF   = 4'd6;
    localparam cmd_idx_t C_MRS    = 4'd7;
    localparam cmd_idx_t C_BST    = 4'd8;
    localparam cmd_idx_t C_SR_IN  = 4'd9;
    localparam cmd_idx_t C_SR_OUT = 4'd10;
    localparam cmd_idx_t C_PD_IN  = 4'd11;
    localparam cmd_idx_t C_PD_OUT = 4'd12;
    localparam cmd_idx_t C_CS_IN  = 4'd13;
    localparam cmd_idx_t C_CS_OUT = 4'd14;

endpackage

// File: rtl/sdr_pin_decode.sv
// Pin-level decode: turns select and strobe pins into a base command index.
// Assumes: active-low pins; clock enable is handled elsewhere.
module sdr_pin_decode
    import sdr_trk_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output cmd_idx_t kind
);

    // Map the strobe pattern to a command index.
    always_comb begin
        if (cs_n) begin
            kind = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  kind = C_NOP;
                3'b110:  kind = C_BST;
                3'b011:  kind = C_ACT;
                3'b101:  kind = C_RD;
                3'b100:  kind = C_WR;
                3'b010:  kind = C_PRE;
                3'b001:  kind = C_AREF;
                default: kind = C_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdr_cmd_judge.sv
// Context decode: combines base command, clock-enable history, device mode,
// bank state and burst status into the final command, legality and effects.
// Assumes: combinational; all state is held by the caller.
module sdr_cmd_judge
    import sdr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  cmd_idx_t             kind,
    input  logic                 cke_prev,
    input  logic                 cke_now,
    input  dev_mode_e            mode,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic [BA_W-1:0]      ba,
    input  logic                 burst_busy,
    output logic [NUM_CMD-1:0]   cmd_vec,
    output logic                 bad,
    output dev_mode_e            mode_nx,
    output logic                 do_act,
    output logic                 do_pre,
    output logic                 do_rw,
    output logic                 do_bst
);

    logic sel_open;
    logic all_idle;
    logic quiet;

    assign sel_open = bank_open[ba];
    assign all_idle = ~|bank_open;
    assign quiet    = (kind == C_NOP) || (kind == C_DESEL);

    // Decide command, legality, mode change and state effects for this edge.
    always_comb begin
        cmd_vec = '0;
        bad     = 1'b0;
        mode_nx = mode;
        do_act  = 1'b0;
        do_pre  = 1'b0;
        do_rw   = 1'b0;
        do_bst  = 1'b0;
        case (mode)
            DM_NORMAL: begin
                if (cke_prev && cke_now) begin
                    cmd_vec[kind] = 1'b1;
                    case (kind)
                        C_ACT:       if (sel_open) bad = 1'b1; else do_act = 1'b1;
                        C_RD, C_WR:  if (!sel_open) bad = 1'b1; else do_rw = 1'b1;
                        C_PRE:       do_pre = 1'b1;
                        C_AREF,
                        C_MRS:       bad = !all_idle;
                        C_BST:       do_bst = 1'b1;
                        default:     ;
                    endcase
                end else if (cke_prev) begin
                    if (burst_busy) begin
                        cmd_vec[C_CS_IN] = 1'b1;
                        mode_nx          = DM_SUSPEND;
                    end else if (kind == C_AREF) begin
                        cmd_vec[C_SR_IN] = 1'b1;
                        if (all_idle) mode_nx = DM_SELFREF;
                        else          bad     = 1'b1;
                    end else if (quiet) begin
                        cmd_vec[C_PD_IN] = 1'b1;
                        mode_nx          = DM_PWRDN;
                    end else begin
                        cmd_vec[kind] = 1'b1;
                        bad           = 1'b1;
                    end
                end
            end
            DM_SELFREF: begin
                if (!cke_prev && cke_now && quiet) begin
                    cmd_vec[C_SR_OUT] = 1'b1;
                    mode_nx           = DM_NORMAL;
                end
            end
            DM_PWRDN: begin
                if (!cke_prev && cke_now) begin
                    cmd_vec[C_PD_OUT] = 1'b1;
                    mode_nx           = DM_NORMAL;
                end
            end
            default: begin
                if (cke_now) begin
                    cmd_vec[C_CS_OUT] = 1'b1;
                    mode_nx           = DM_NORMAL;
                end
            end
        endcase
    end

endmodule

// File: rtl/sdr_bank_track.sv
// Bank open/closed flags and burst counter with auto-precharge close.
// Assumes: effect strobes are already qualified by legality; run is low
// whenever the clock is suspended or the device is in a low-power mode.
module sdr_bank_track #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 do_act,
    input  logic                 do_pre,
    input  logic                 do_rw,
    input  logic                 do_bst,
    input  logic                 run,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 busy
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic [CNT_W-1:0]     cnt_q, cnt_nx;
    logic [BA_W-1:0]      bbank_q;
    logic                 bap_q;
    logic [NUM_BANKS-1:0] open_nx;
    logic                 end_close;

    assign busy = (cnt_q != '0);

    // Next bank flags and burst count from this edge's effects.
    always_comb begin
        open_nx   = bank_open;
        cnt_nx    = cnt_q;
        end_close = 1'b0;
        if (do_rw) begin
            end_close = busy && bap_q && (bbank_q != ba);
            cnt_nx    = CNT_W'(BURST_LEN);
        end else if (do_bst) begin
            end_close = busy && bap_q;
            cnt_nx    = '0;
        end else if (run && busy) begin
            cnt_nx    = cnt_q - 1'b1;
            end_close = bap_q && (cnt_q == CNT_W'(1));
        end
        if (end_close) open_nx[bbank_q] = 1'b0;
        if (do_pre) begin
            if (a10) open_nx = '0;
            else     open_nx[ba] = 1'b0;
        end
        if (do_act) open_nx[ba] = 1'b1;
    end

    // Register bank flags, burst count and the burst's bank/auto-precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_open <= '0;
            cnt_q     <= '0;
            bbank_q   <= '0;
            bap_q     <= 1'b0;
        end else begin
            bank_open <= open_nx;
            cnt_q     <= cnt_nx;
            if (do_rw) begin
                bbank_q <= ba;
                bap_q   <= a10;
            end
        end
    end

endmodule

// File: rtl/sdr_cmd_tracker.sv
// Top: samples SDRAM control pins each rising edge, decodes them in context
// and registers the decoded command, flags, device mode and bank state.
// Assumes: clock enable is high during reset.
module sdr_cmd_tracker
    import sdr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 dqm,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic [NUM_CMD-1:0]   cmd_o,
    output logic [BA_W-1:0]      bank_o,
    output logic                 ap_o,
    output logic [1:0]           mode_o,
    output logic                 illegal_o,
    output logic                 data_en_o,
    output logic [NUM_BANKS-1:0] bank_open_o
);

    cmd_idx_t             kind;
    logic                 cke_q;
    dev_mode_e            mode_q, mode_nx;
    logic [NUM_CMD-1:0]   cmd_vec;
    logic                 bad, do_act, do_pre, do_rw, do_bst, busy, run;

    assign run    = (mode_q == DM_NORMAL) && cke_q && cke;
    assign mode_o = mode_q;

    sdr_pin_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .kind  (kind)
    );

    sdr_cmd_judge #(.NUM_BANKS(NUM_BANKS)) u_judge (
        .kind       (kind),
        .cke_prev   (cke_q),
        .cke_now    (cke),
        .mode       (mode_q),
        .bank_open  (bank_open_o),
        .ba         (ba),
        .burst_busy (busy),
        .cmd_vec    (cmd_vec),
        .bad        (bad),
        .mode_nx    (mode_nx),
        .do_act     (do_act),
        .do_pre     (do_pre),
        .do_rw      (do_rw),
        .do_bst     (do_bst)
    );

    sdr_bank_track #(.NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_act    (do_act),
        .do_pre    (do_pre),
        .do_rw     (do_rw),
        .do_bst    (do_bst),
        .run       (run),
        .ba        (ba),
        .a10       (a10),
        .bank_open (bank_open_o),
        .busy      (busy)
    );

    // Register clock-enable history, device mode and the output command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q     <= 1'b1;
            mode_q    <= DM_NORMAL;
            cmd_o     <= '0;
            bank_o    <= '0;
            ap_o      <= 1'b0;
            illegal_o <= 1'b0;
            data_en_o <= 1'b0;
        end else begin
            cke_q     <= cke;
            mode_q    <= mode_nx;
            cmd_o     <= cmd_vec;
            bank_o    <= ba;
            ap_o      <= a10 && (cmd_vec[C_PRE] || cmd_vec[C_RD] || cmd_vec[C_WR]);
            illegal_o <= bad;
            data_en_o <= cke_q && !dqm;
        end
    end

endmodule

// File: rtl/sdr_cmd_tracker_chk.sv
// Checker for sdr_cmd_tracker: relates registered command, mode and bank state.
// Assumes: bound to every instance of the top; reset held at least one edge.
module sdr_cmd_tracker_chk
    import sdr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CMD-1:0]   cmd_o,
    input logic [BA_W-1:0]      bank_o,
    input logic                 ap_o,
    input logic [1:0]           mode_o,
    input logic                 illegal_o,
    input logic [NUM_BANKS-1:0] bank_open_o
);

    p_cmd_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_o));

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[C_ACT] |-> bank_open_o[bank_o]);

    p_rw_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o[C_RD] || cmd_o[C_WR]) && !illegal_o) |-> bank_open_o[bank_o]);

    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_PRE] && ap_o) |-> (bank_open_o == '0));

    p_mrs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o[C_MRS] || cmd_o[C_AREF]) && !illegal_o) |-> (bank_open_o == '0));

    p_sref_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_SR_IN] && !illegal_o) |-> (mode_o == DM_SELFREF && bank_open_o == '0));

    p_pd_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[C_PD_OUT] |-> (mode_o == DM_NORMAL && $past(mode_o) == DM_PWRDN));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) != DM_NORMAL) |-> (!illegal_o && $stable(bank_open_o)));

endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .ap_o        (ap_o),
    .mode_o      (mode_o),
    .illegal_o   (illegal_o),
    .bank_open_o (bank_open_o)
);

// File: tb/sim_sdr_cmd_tracker.sv
// Directed bench for sdr_cmd_tracker: one task per scenario.
module sim_sdr_cmd_tracker;

    localparam int K_DESEL = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4, K_PRE = 5,
                   K_AREF = 6, K_MRS = 7, K_BST = 8, K_SRIN = 9, K_SROUT = 10,
                   K_PDIN = 11, K_PDOUT = 12, K_CSIN = 13, K_CSOUT = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        dqm = 1'b0;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [14:0] cmd_o;
    logic [1:0]  bank_o;
    logic        ap_o;
    logic [1:0]  mode_o;
    logic        illegal_o;
    logic        data_en_o;
    logic [3:0]  bank_open_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdr_cmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .a10(a10),
        .cmd_o(cmd_o), .bank_o(bank_o), .ap_o(ap_o), .mode_o(mode_o),
        .illegal_o(illegal_o), .data_en_o(data_en_o), .bank_open_o(bank_open_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one command on the falling edge; return 1 ns after the sampling edge.
    task automatic issue(input int k, input int b, input logic a, input logic ck);
        @(negedge clk);
        cke = ck; ba = 2'(b); a10 = a; cs_n = 1'b0;
        case (k)
            K_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b101; end
            K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            K_RD:    {ras_n, cas_n, we_n} = 3'b101;
            K_WR:    {ras_n, cas_n, we_n} = 3'b100;
            K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            K_AREF:  {ras_n, cas_n, we_n} = 3'b001;
            K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
            K_BST:   {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic close_all();
        issue(K_BST, 0, 1'b0, 1'b1);
        issue(K_PRE, 0, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        chk("R13 cmd", int'(cmd_o), 0);
        chk("R13 mode", int'(mode_o), 0);
        chk("R13 banks", int'(bank_open_o), 0);
        chk("R13 illegal", int'(illegal_o), 0);
        chk("R13 ap", int'(ap_o), 0);
    endtask

    task automatic t_decode();
        issue(K_DESEL, 2, 1'b0, 1'b1);
        chk("R1 deselect", int'(cmd_o), 1 << K_DESEL);
        chk("R1 deselect banks", int'(bank_open_o), 0);
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R1 nop", int'(cmd_o), 1 << K_NOP);
        issue(K_BST, 0, 1'b0, 1'b1);
        chk("R1 burst stop", int'(cmd_o), 1 << K_BST);
    endtask

    task automatic t_act();
        issue(K_ACT, 1, 1'b0, 1'b1);
        chk("R2 act cmd", int'(cmd_o), 1 << K_ACT);
        chk("R2 act legal", int'(illegal_o), 0);
        chk("R2 act opens", int'(bank_open_o), 4'b0010);
        issue(K_ACT, 1, 1'b0, 1'b1);
        chk("R2 act on open", int'(illegal_o), 1);
        chk("R2 act on open state", int'(bank_open_o), 4'b0010);
        issue(K_ACT, 3, 1'b0, 1'b1);
        chk("R2 second bank", int'(bank_open_o), 4'b1010);
    endtask

    task automatic t_rw();
        issue(K_RD, 2, 1'b0, 1'b1);
        chk("R3 read closed bank", int'(illegal_o), 1);
        issue(K_RD, 3, 1'b0, 1'b1);
        chk("R3 read legal", int'(illegal_o), 0);
        chk("R3 read cmd", int'(cmd_o), 1 << K_RD);
        chk("R3 read bank", int'(bank_o), 3);
        chk("R3 read ap", int'(ap_o), 0);
        issue(K_WR, 1, 1'b0, 1'b1);
        chk("R3 write cmd", int'(cmd_o), 1 << K_WR);
        chk("R3 write legal", int'(illegal_o), 0);
        issue(K_MRS, 0, 1'b1, 1'b1);
        chk("R3 ap only on rw/pre", int'(ap_o), 0);
        issue(K_BST, 0, 1'b0, 1'b1);
    endtask

    task automatic t_pre();
        issue(K_ACT, 0, 1'b0, 1'b1);
        issue(K_PRE, 1, 1'b0, 1'b1);
        chk("R4 single precharge", int'(bank_open_o), 4'b1001);
        chk("R4 single ap", int'(ap_o), 0);
        issue(K_PRE, 0, 1'b1, 1'b1);
        chk("R4 all precharge", int'(bank_open_o), 0);
        chk("R4 all ap", int'(ap_o), 1);
    endtask

    task automatic t_mrs();
        issue(K_ACT, 2, 1'b0, 1'b1);
        issue(K_MRS, 0, 1'b0, 1'b1);
        chk("R5 mode set with open bank", int'(illegal_o), 1);
        issue(K_AREF, 0, 1'b0, 1'b1);
        chk("R5 refresh with open bank", int'(illegal_o), 1);
        issue(K_PRE, 0, 1'b1, 1'b1);
        issue(K_MRS, 0, 1'b0, 1'b1);
        chk("R5 mode set idle", int'(illegal_o), 0);
        chk("R5 mode set cmd", int'(cmd_o), 1 << K_MRS);
        issue(K_AREF, 0, 1'b0, 1'b1);
        chk("R5 refresh idle", int'(illegal_o), 0);
    endtask

    task automatic t_autopre();
        issue(K_ACT, 1, 1'b0, 1'b1);
        issue(K_RD, 1, 1'b1, 1'b1);
        chk("R6 ap flag", int'(ap_o), 1);
        for (int i = 0; i < 3; i++) issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R6 open after 3", int'(bank_open_o), 4'b0010);
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R6 closed after 4", int'(bank_open_o), 0);
    endtask

    task automatic t_bst();
        issue(K_ACT, 2, 1'b0, 1'b1);
        issue(K_WR, 2, 1'b1, 1'b1);
        issue(K_NOP, 0, 1'b0, 1'b1);
        issue(K_BST, 0, 1'b0, 1'b1);
        chk("R7 stop closes ap bank", int'(bank_open_o), 0);
        issue(K_ACT, 0, 1'b0, 1'b1);
        issue(K_ACT, 1, 1'b0, 1'b1);
        issue(K_RD, 0, 1'b1, 1'b1);
        issue(K_RD, 1, 1'b0, 1'b1);
        chk("R7 interrupt closes ap bank", int'(bank_open_o), 4'b0010);
        close_all();
    endtask

    task automatic t_sref();
        issue(K_AREF, 0, 1'b0, 1'b0);
        chk("R8 sref entry cmd", int'(cmd_o), 1 << K_SRIN);
        chk("R8 sref mode", int'(mode_o), 1);
        issue(K_ACT, 0, 1'b0, 1'b0);
        chk("R11 sref ignore cmd", int'(cmd_o), 0);
        chk("R11 sref no illegal", int'(illegal_o), 0);
        chk("R11 sref banks", int'(bank_open_o), 0);
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R8 sref exit cmd", int'(cmd_o), 1 << K_SROUT);
        chk("R8 sref exit mode", int'(mode_o), 0);
        issue(K_ACT, 0, 1'b0, 1'b1);
        issue(K_AREF, 0, 1'b0, 1'b0);
        chk("R8 sref entry with open bank", int'(illegal_o), 1);
        chk("R8 sref refused mode", int'(mode_o), 0);
        issue(K_NOP, 0, 1'b0, 1'b1);
        issue(K_PRE, 0, 1'b1, 1'b1);
    endtask

    task automatic t_pd();
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R9 pd entry cmd", int'(cmd_o), 1 << K_PDIN);
        chk("R9 pd mode", int'(mode_o), 2);
        issue(K_RD, 0, 1'b0, 1'b0);
        chk("R11 pd ignore cmd", int'(cmd_o), 0);
        chk("R11 pd no illegal", int'(illegal_o), 0);
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R9 pd exit cmd", int'(cmd_o), 1 << K_PDOUT);
        chk("R9 pd exit mode", int'(mode_o), 0);
    endtask

    task automatic t_susp();
        issue(K_ACT, 0, 1'b0, 1'b1);
        issue(K_RD, 0, 1'b0, 1'b1);
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R10 suspend entry", int'(cmd_o), 1 << K_CSIN);
        chk("R10 suspend mode", int'(mode_o), 3);
        for (int i = 0; i < 3; i++) issue(K_ACT, 1, 1'b0, 1'b0);
        chk("R11 suspend ignore", int'(cmd_o), 0);
        chk("R11 suspend banks", int'(bank_open_o), 4'b0001);
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R10 suspend exit", int'(cmd_o), 1 << K_CSOUT);
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R10 burst frozen", int'(cmd_o), 1 << K_CSIN);
        issue(K_NOP, 0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) issue(K_NOP, 0, 1'b0, 1'b1);
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R10 burst done then pd", int'(cmd_o), 1 << K_PDIN);
        issue(K_NOP, 0, 1'b0, 1'b1);
        issue(K_PRE, 0, 1'b1, 1'b1);
    endtask

    task automatic t_data();
        dqm = 1'b0;
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R12 enabled", int'(data_en_o), 1);
        dqm = 1'b1;
        issue(K_NOP, 0, 1'b0, 1'b1);
        chk("R12 masked", int'(data_en_o), 0);
        dqm = 1'b0;
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R12 cke was high", int'(data_en_o), 1);
        issue(K_NOP, 0, 1'b0, 1'b0);
        chk("R12 cke was low", int'(data_en_o), 0);
        issue(K_NOP, 0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_decode();
        t_act();
        t_rw();
        t_pre();
        t_mrs();
        t_autopre();
        t_bst();
        t_sref();
        t_pd();
        t_susp();
        t_data();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule